// File: doc/BRIEF.md
# SCSI Controller Command Register Block

This block is the host-side register file and command decoder of a small SCSI protocol controller. A host reaches sixteen byte-wide registers through a single read/write port. The register index is the bus address shifted right by a parameter, so the block can sit on a bus with wider register strides. Each index has two images. A write lands in the write image. A read returns the read image. For most registers the two are the same. For the status, interrupt-reason, sequence-step, FIFO-flags and chip-identification registers a write has no visible effect. For the two transfer-count byte registers the written value stays hidden until a command carrying the DMA flag copies it across.

A byte written to the command register is decoded into a fixed update of the status, interrupt-reason, sequence-step and FIFO-flags registers. A command may also raise the interrupt. Bit 7 of the status register is the interrupt-pending flag, and the level interrupt output follows it. Reading the interrupt-reason register returns the old value and acknowledges it. The bus phases, the data movement and the targets are outside the block. A single completion strobe stands in for them.

Top module: `scsi_cmd_regs`

## Requirements
- R1: After reset every read register returns 0, except index 7 (chip ID), which returns 0x04, and index 8 (configuration 1), which returns 0x07; irq and cmd_err are low.
- R2: The register index is addr >> ADDR_SHIFT (default 2), truncated to 4 bits; the address bits below the shift are ignored. A read returns the old value one cycle after rd_en.
- R3: irq equals status bit 7 (index 0, mask 0x80); it rises only after a command write or a cmd_done strobe.
- R4: Reading index 1 (interrupt reason) returns its old value and then clears it to 0. The same read clears status bits 7 and 4, sets the sequence step (index 2) to 0x04 and lowers irq.
- R5: Writes to index 5 (count low) and index 6 (count mid) do not change what those indices read back. Each such write clears status bit 4 (terminal count, 0x10). Index 4 is the command register. Its bits 6:0 are the code and bit 7 is the DMA flag. A recognised command with the DMA flag set reloads indices 5 and 6 from the values last written to them. Together, indices 5 and 6 form the 16-bit count low | mid<<8.
- R6: Command 0x01 sets the interrupt reason to 0x08, clears the sequence step and the FIFO flags (index 3), and raises irq.
- R7: Command 0x03 sets the interrupt reason to 0x80. It raises irq only when bit 6 (0x40) of the last value written to configuration 1 is clear.
- R8: Command 0x12 sets the interrupt reason to 0x20, clears the sequence step and raises irq. Command 0x44 clears the interrupt reason and leaves irq unchanged.
- R9: Command 0x11 sets the interrupt reason to 0x08, ORs 0x07 into the status register and raises irq.
- R10: Command 0x02 returns both register images to the R1 reset values. Command 0x00 changes nothing except the readable command register and, when the DMA flag is set, the R5 reload.
- R11: Any other command code leaves every register unchanged and pulses cmd_err high for exactly one cycle, the cycle after the write.
- R12: A cmd_done pulse sets status bit 4 and bit 7 and sets the interrupt reason to 0x10. It also clears the sequence step, the FIFO flags and count indices 5 and 6.
- R13: Writes to indices 0, 1, 2, 3 and 7 do not change their read values. Writes to index 8 and to indices 9 to 15 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; the index is addr >> ADDR_SHIFT |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| cmd_done | input | 1 | Completion strobe from the transfer side |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| cmd_err | output | 1 | One-cycle pulse on an unrecognised command |

## Verification
The assertions assume that the host never asserts rd_en and wr_en in the same cycle. They also assume that cmd_done never arrives in the same cycle as a host access, so each cycle applies exactly one kind of update. The stimulus keeps to this because one task drives each kind of operation and holds it for a single clock, with every strobe low between operations. The random command bytes come from a list of recognised codes plus a few unrecognised ones, with a random DMA flag, so every decode path and the reload are reached many times.

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2,
  parameter int NREG       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              cmd_done,
  output logic              irq,
  output logic              cmd_err
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [IDX_W-1:0] R_STAT = 0, R_INTR = 1, R_SEQ = 2, R_FLAG = 3,
                               R_CMD = 4, R_TCLO = 5, R_TCMID = 6, R_TCHI = 7,
                               R_CFG1 = 8;
  localparam logic [7:0] ST_IRQ = 8'h80, ST_TC = 8'h10, ST_MSGIN = 8'h07;
  localparam logic [7:0] IR_FC = 8'h08, IR_BS = 8'h10, IR_DC = 8'h20, IR_RST = 8'h80;
  localparam logic [7:0] SEQ_DONE = 8'h04, CHIP_ID = 8'h04, CFG1_RST = 8'h07;

  logic [7:0] rimg [NREG];
  logic [7:0] wimg [NREG];
  logic [7:0] rnx  [NREG];
  logic [7:0] wnx  [NREG];
  logic [ADDR_W-1:0] shifted;
  logic [IDX_W-1:0]  idx;
  logic err_nx, do_rst;

  assign shifted = addr >> ADDR_SHIFT;
  assign idx     = shifted[IDX_W-1:0];
  assign irq     = rimg[R_STAT][7];

  always_comb begin
    rnx    = rimg;
    wnx    = wimg;
    err_nx = 1'b0;
    do_rst = 1'b0;
    if (wr_en) begin
      wnx[idx] = wr_data;
      case (idx)
        R_TCLO, R_TCMID: rnx[R_STAT] = rimg[R_STAT] & ~ST_TC;
        R_STAT, R_INTR, R_SEQ, R_FLAG, R_TCHI: ;
        R_CMD: begin
          rnx[R_CMD] = wr_data;
          case (wr_data[6:0])
            7'h00: ;
            7'h01: begin
              rnx[R_INTR] = IR_FC;
              rnx[R_SEQ]  = 8'h00;
              rnx[R_FLAG] = 8'h00;
              rnx[R_STAT] = rnx[R_STAT] | ST_IRQ;
            end
            7'h02: do_rst = 1'b1;
            7'h03: begin
              rnx[R_INTR] = IR_RST;
              if (!wimg[R_CFG1][6]) rnx[R_STAT] = rnx[R_STAT] | ST_IRQ;
            end
            7'h11: begin
              rnx[R_INTR] = IR_FC;
              rnx[R_STAT] = rnx[R_STAT] | ST_MSGIN | ST_IRQ;
            end
            7'h12: begin
              rnx[R_INTR] = IR_DC;
              rnx[R_SEQ]  = 8'h00;
              rnx[R_STAT] = rnx[R_STAT] | ST_IRQ;
            end
            7'h44: rnx[R_INTR] = 8'h00;
            default: begin
              err_nx     = 1'b1;
              rnx[R_CMD] = rimg[R_CMD];
              wnx[R_CMD] = wimg[R_CMD];
            end
          endcase
          if (wr_data[7] && !err_nx) begin
            rnx[R_TCLO]  = wimg[R_TCLO];
            rnx[R_TCMID] = wimg[R_TCMID];
          end
        end
        default: rnx[idx] = wr_data;
      endcase
    end else if (rd_en && idx == R_INTR) begin
      rnx[R_INTR] = 8'h00;
      rnx[R_STAT] = rimg[R_STAT] & ~(ST_TC | ST_IRQ);
      rnx[R_SEQ]  = SEQ_DONE;
    end
    if (cmd_done) begin
      rnx[R_STAT]  = rnx[R_STAT] | ST_TC | ST_IRQ;
      rnx[R_INTR]  = IR_BS;
      rnx[R_SEQ]   = 8'h00;
      rnx[R_FLAG]  = 8'h00;
      rnx[R_TCLO]  = 8'h00;
      rnx[R_TCMID] = 8'h00;
    end
    if (do_rst) begin
      for (int i = 0; i < NREG; i++) begin
        rnx[i] = 8'h00;
        wnx[i] = 8'h00;
      end
      rnx[R_TCHI] = CHIP_ID;
      rnx[R_CFG1] = CFG1_RST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rimg[i] <= 8'h00;
        wimg[i] <= 8'h00;
      end
      rimg[R_TCHI] <= CHIP_ID;
      rimg[R_CFG1] <= CFG1_RST;
      rd_data <= 8'h00;
      cmd_err <= 1'b0;
    end else begin
      rimg    <= rnx;
      wimg    <= wnx;
      cmd_err <= err_nx;
      if (rd_en) rd_data <= rimg[idx];
    end
  end

  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en || cmd_done));
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_en || wr_en));
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == R_INTR && !cmd_done) |=> (rimg[R_INTR] == 8'h00 && !irq));
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(wr_en && idx == R_CMD));
  p_chip_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rimg[R_TCHI] == CHIP_ID);
endmodule

// File: tb/scsi_cmd_regs_test.sv
module scsi_cmd_regs_test;
  localparam int SH = 2;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wr_data = 0;
  logic wr_en = 0, rd_en = 0, cmd_done = 0;
  logic [7:0] rd_data;
  logic irq, cmd_err;
  int vecs = 0, bad = 0;
  bit [7:0] mr [16];
  bit [7:0] mw [16];

  scsi_cmd_regs #(.ADDR_W(8), .ADDR_SHIFT(SH), .NREG(16)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .cmd_done(cmd_done),
    .irq(irq), .cmd_err(cmd_err));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic string req_of(int i);
    case (i)
      0: return "R3 status";
      1: return "R4 intr";
      2: return "R6 seq";
      3: return "R12 flags";
      4: return "R10 cmd";
      5, 6: return "R5 count";
      7: return "R1 id";
      default: return "R13 spare";
    endcase
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 16; i++) begin mr[i] = 0; mw[i] = 0; end
    mr[7] = 8'h04;
    mr[8] = 8'h07;
  endfunction

  function automatic bit m_write(int i, bit [7:0] v);
    bit known = 1;
    if (i == 4) begin
      case (v[6:0])
        7'h00: ;
        7'h01: begin mr[1] = 8'h08; mr[2] = 0; mr[3] = 0; mr[0][7] = 1; end
        7'h02: ;
        7'h03: begin mr[1] = 8'h80; if (!mw[8][6]) mr[0][7] = 1; end
        7'h11: begin mr[1] = 8'h08; mr[0] = mr[0] | 8'h87; end
        7'h12: begin mr[1] = 8'h20; mr[2] = 0; mr[0][7] = 1; end
        7'h44: mr[1] = 0;
        default: known = 0;
      endcase
      if (!known) return 1;
      mw[4] = v;
      mr[4] = v;
      if (v[7]) begin mr[5] = mw[5]; mr[6] = mw[6]; end
      if (v[6:0] == 7'h02) m_reset();
      return 0;
    end
    mw[i] = v;
    if (i == 5 || i == 6) mr[0][4] = 0;
    else if (i >= 8) mr[i] = v;
    return 0;
  endfunction

  task automatic wr(int i, bit [7:0] v);
    bit e;
    @(negedge clk);
    addr = 8'((i << SH) | int'($urandom_range(0, 3)));
    wr_data = v;
    wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    e = m_write(i, v);
    chk(i == 4 ? "R11 err" : "R13 err", {7'b0, cmd_err}, {7'b0, e});
    chk("R3 irq", {7'b0, irq}, {7'b0, mr[0][7]});
  endtask

  task automatic rd(int i);
    bit [7:0] exp;
    @(negedge clk);
    addr = 8'(i << SH);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    exp = mr[i];
    if (i == 1) begin mr[1] = 0; mr[0] = mr[0] & 8'h6F; mr[2] = 8'h04; end
    chk(req_of(i), rd_data, exp);
    chk("R4 irq", {7'b0, irq}, {7'b0, mr[0][7]});
  endtask

  task automatic done();
    @(negedge clk);
    cmd_done = 1;
    @(negedge clk);
    cmd_done = 0;
    mr[0] = mr[0] | 8'h90; mr[1] = 8'h10; mr[2] = 0; mr[3] = 0; mr[5] = 0; mr[6] = 0;
    chk("R12 irq", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    bit [7:0] cmds [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h11, 8'h12, 8'h44, 8'h10, 8'h42, 8'h05};
    void'($urandom(32'h5C51));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 irq", {7'b0, irq}, 0);
    chk("R1 err", {7'b0, cmd_err}, 0);
    for (int i = 0; i < 16; i++) rd(i);
    // R2: low address bits ignored
    wr(9, 8'hA5); rd(9);
    // R5: hidden count, reload by DMA-flagged command
    wr(5, 8'h34); wr(6, 8'h12); rd(5); rd(6);
    wr(4, 8'h80); rd(5); rd(6);
    // R7: bus reset with report suppressed, then allowed
    wr(8, 8'h47); wr(4, 8'h03); rd(1);
    wr(8, 8'h07); wr(4, 8'h03); rd(0); rd(1); rd(0); rd(2);
    // R9 and R8
    wr(4, 8'h11); rd(0); rd(1);
    wr(4, 8'h12); rd(1); wr(4, 8'h44); rd(1);
    // R11: unknown code changes nothing
    wr(4, 8'hC2); rd(4); rd(5);
    // R12 then R10 chip reset
    done(); rd(5); rd(1);
    wr(4, 8'h02);
    for (int i = 0; i < 16; i++) rd(i);
    // R6 flush
    wr(4, 8'h01); rd(2); rd(3); rd(1);
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) rd($urandom_range(0, 15));
      else if (op < 7) wr(4, {1'($urandom_range(0, 1)), 7'b0} | cmds[$urandom_range(0, 9)]);
      else if (op < 9) wr($urandom_range(0, 15), 8'($urandom));
      else done();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule